// File: doc/BRIEF.md
# CAS-before-RAS Refresh Scheduler

This block keeps a page-mode DRAM alive without help from the access controller's address path. A free-running interval timer adds one owed refresh to a small saturating counter each period. While anything is owed, the block raises a request toward the access controller. Once the bus is granted and reported quiet, the block drives the row strobe and both column strobes itself. Each refresh lowers the column strobes ahead of the row strobe, so the memory supplies the row from its own counter and no address is needed. Owed refreshes are paid off back to back in one ownership period: the column strobes stay low and only the row strobe is cycled.

A sleep command makes the block take the bus and park the memory in self-refresh. Both strobes are held low for at least a minimum time and until a wake command arrives. On exit the block releases all strobes for a long precharge, then runs a refresh of every row before it hands the bus back. The interval timer is stopped while self-refresh and its closing burst are in progress.

Every interval is a parameter counted in system clocks. A single parameter selects the standard refresh period or the longer period of the low-power memory.

Top module: `cbr_refresh_sched`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `ref_req` and `busy` are 0 and `ras_n`, `lcas_n` and `ucas_n` are 1.
- R2: One refresh becomes owed every IVAL clocks, where IVAL is STD_IVAL when LOW_POWER is 0 and LP_IVAL otherwise. The first `ref_req` is seen IVAL cycles after reset is released.
- R3: A bus session starts only on a cycle in which `ref_req`, `ref_gnt` and `bus_idle` are all 1, and `busy` is 1 in the next cycle. `ref_req` is 0 whenever `busy` is 1.
- R4: Each refresh holds both column strobes low with `ras_n` high for T_CSR cycles. It then holds `ras_n` low for T_RAS cycles with both column strobes still low. `ras_n` is never low while a column strobe is high.
- R5: With k refreshes owed at grant, the session contains k row-strobe pulses. Between pulses `ras_n` is high for T_RP cycles while the column strobes stay low.
- R6: After the last pulse, all strobes are high for T_RP cycles, then `busy` falls. `ref_req` is then 0 if nothing new became owed.
- R7: The owed-refresh count saturates at 2^PEND_W-1. Further periods that pass without service are lost.
- R8: A one-cycle `sleep_req` raises `ref_req`. After grant, the column strobes lead by T_CSR cycles, then `ras_n` and both column strobes stay low for at least T_SELF cycles. Refreshes owed at that point are discarded.
- R9: A `wake_req` seen before T_SELF cycles of self-refresh have passed is remembered, and the exit happens right after T_SELF cycles. A later `wake_req` ends self-refresh at the next clock edge. A `wake_req` outside self-refresh has no effect.
- R10: On leaving self-refresh, all strobes are high for T_RPS cycles. A chained burst of ROWS refreshes follows, shaped as in R4 to R6, before `busy` falls.
- R11: The interval timer is held during self-refresh and its burst. The first `ref_req` after that session comes IVAL cycles after `busy` falls.
- R12: Whenever `busy` is 0, `ras_n`, `lcas_n` and `ucas_n` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | One-cycle command to enter self-refresh |
| wake_req | input | 1 | One-cycle command to leave self-refresh |
| ref_gnt | input | 1 | Bus grant from the access controller |
| bus_idle | input | 1 | Access controller reports all strobes high and precharge met |
| ref_req | output | 1 | Bus request toward the access controller |
| busy | output | 1 | Block owns the strobes |
| ras_n | output | 1 | Row strobe, active low |
| lcas_n | output | 1 | Lower-byte column strobe, active low |
| ucas_n | output | 1 | Upper-byte column strobe, active low |

## Verification
All outputs decode the registered state, so any result lands exactly one clock after the edge that causes it. A grant sampled at an edge shows as `busy` one cycle later, and `ref_req` rises in the sample right after the timer edge that adds an owed refresh. The bench drives and samples on the falling clock edge and keeps an absolute cycle count from reset release. It times each grant to follow a timer tick at once, so no tick can land inside a session and change how many pulses are expected. Each session is recorded as a run-length list of strobe levels and compared in full, segment by segment, with a list built from the requirement's cycle counts.

// File: rtl/cbr_refresh_sched.sv
module cbr_refresh_sched #(
  parameter int LOW_POWER = 0,
  parameter int STD_IVAL  = 1950,
  parameter int LP_IVAL   = 15625,
  parameter int PEND_W    = 3,
  parameter int ROWS      = 512,
  parameter int T_CSR     = 2,
  parameter int T_RAS     = 8,
  parameter int T_RP      = 5,
  parameter int T_RPS     = 14,
  parameter int T_SELF    = 12500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_req,
  input  logic wake_req,
  input  logic ref_gnt,
  input  logic bus_idle,
  output logic ref_req,
  output logic busy,
  output logic ras_n,
  output logic lcas_n,
  output logic ucas_n
);
  localparam int IVAL = (LOW_POWER != 0) ? LP_IVAL : STD_IVAL;
  localparam int IW   = $clog2(IVAL + 1);
  localparam int TW   = $clog2(T_CSR + T_RAS + T_RP + T_RPS + T_SELF + 1);
  localparam int BW   = $clog2(ROWS + 1);
  localparam logic [PEND_W-1:0] PEND_MAX = '1;

  typedef enum logic [2:0] {S_IDLE, S_LEAD, S_RLOW, S_PRE, S_HOLD, S_EXIT} st_t;

  st_t              st;
  logic [TW-1:0]    tmr;
  logic [IW-1:0]    iv;
  logic [PEND_W-1:0] pend, pend_nx;
  logic [BW-1:0]    burst;
  logic             in_burst, chain, sleep_pend, wake_pend;
  logic             self_mode, tick, done_one, tmr_z, to_hold;

  assign tmr_z     = (tmr == '0);
  assign self_mode = (st == S_HOLD) || (st == S_EXIT) || in_burst;
  assign tick      = !self_mode && (iv == '0);
  assign done_one  = (st == S_RLOW) && tmr_z && !in_burst;
  assign to_hold   = (st == S_LEAD) && tmr_z && sleep_pend && !in_burst;

  assign ref_req = (st == S_IDLE) && ((pend != '0) || sleep_pend);
  assign busy    = (st != S_IDLE);
  assign ras_n   = !((st == S_RLOW) || (st == S_HOLD));
  assign lcas_n  = !((st == S_LEAD) || (st == S_RLOW) || (st == S_HOLD) ||
                     ((st == S_PRE) && chain));
  assign ucas_n  = lcas_n;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                   iv <= IW'(IVAL - 1);
    else if (self_mode || iv == '0) iv <= IW'(IVAL - 1);
    else                          iv <= iv - 1'b1;

  always_comb begin
    pend_nx = pend;
    if (tick && !done_one && pend != PEND_MAX)   pend_nx = pend + 1'b1;
    else if (done_one && !tick && pend != '0)    pend_nx = pend - 1'b1;
    if (to_hold)                                 pend_nx = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; tmr <= '0; pend <= '0; burst <= '0;
      in_burst <= 1'b0; chain <= 1'b0; sleep_pend <= 1'b0; wake_pend <= 1'b0;
    end else begin
      pend <= pend_nx;
      if (sleep_req && !self_mode) sleep_pend <= 1'b1;
      case (st)
        S_IDLE:
          if (ref_req && ref_gnt && bus_idle) begin
            st <= S_LEAD; tmr <= TW'(T_CSR - 1);
          end
        S_LEAD:
          if (!tmr_z) tmr <= tmr - 1'b1;
          else if (to_hold) begin
            st <= S_HOLD; tmr <= TW'(T_SELF - 1);
            sleep_pend <= 1'b0; wake_pend <= 1'b0;
          end else begin
            st <= S_RLOW; tmr <= TW'(T_RAS - 1);
          end
        S_RLOW:
          if (!tmr_z) tmr <= tmr - 1'b1;
          else begin
            st <= S_PRE; tmr <= TW'(T_RP - 1);
            if (in_burst) begin
              burst <= burst - 1'b1;
              chain <= (burst != BW'(1));
            end else chain <= (pend_nx != '0);
          end
        S_PRE:
          if (!tmr_z) tmr <= tmr - 1'b1;
          else if (chain) begin
            st <= S_RLOW; tmr <= TW'(T_RAS - 1);
          end else begin
            st <= S_IDLE; in_burst <= 1'b0;
          end
        S_HOLD: begin
          if (wake_req) wake_pend <= 1'b1;
          if (!tmr_z) tmr <= tmr - 1'b1;
          else if (wake_pend || wake_req) begin
            st <= S_EXIT; tmr <= TW'(T_RPS - 1);
          end
        end
        S_EXIT:
          if (!tmr_z) tmr <= tmr - 1'b1;
          else begin
            st <= S_LEAD; tmr <= TW'(T_CSR - 1);
            in_burst <= 1'b1; burst <= BW'(ROWS);
          end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cbr_refresh_sched_chk.sv
module cbr_refresh_sched_chk #(
  parameter int T_RAS = 8,
  parameter int T_RP  = 5
) (
  input logic clk,
  input logic rst_n,
  input logic ref_gnt,
  input logic bus_idle,
  input logic ref_req,
  input logic busy,
  input logic ras_n,
  input logic lcas_n,
  input logic ucas_n
);
  logic [15:0] lo_cnt, hi_cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lo_cnt <= '0; hi_cnt <= '0;
    end else if (!ras_n) begin
      lo_cnt <= (lo_cnt == 16'hFFFF) ? lo_cnt : lo_cnt + 1'b1;
      hi_cnt <= '0;
    end else begin
      hi_cnt <= (hi_cnt == 16'hFFFF) ? hi_cnt : hi_cnt + 1'b1;
      lo_cnt <= '0;
    end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (ras_n && lcas_n && ucas_n)); // R12
  AST_RAS_NEEDS_CAS: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> (!lcas_n && !ucas_n)); // R4
  AST_CAS_LEADS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> $past(!lcas_n && !ucas_n)); // R4
  AST_RAS_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> (lo_cnt >= 16'(T_RAS))); // R4
  AST_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (hi_cnt >= 16'(T_RP))); // R6
  AST_GRANT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(ref_req && ref_gnt && bus_idle)); // R3
  AST_REQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ref_req); // R3
endmodule

bind cbr_refresh_sched cbr_refresh_sched_chk #(.T_RAS(T_RAS), .T_RP(T_RP)) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .bus_idle(bus_idle),
  .ref_req(ref_req), .busy(busy), .ras_n(ras_n), .lcas_n(lcas_n), .ucas_n(ucas_n));

// File: tb/test_cbr_refresh_sched.sv
`timescale 1ns/1ps
module test_cbr_refresh_sched;
  localparam int IVAL = 40, LPI = 80, PW = 2, ROWS = 4;
  localparam int TCSR = 2, TRAS = 4, TRP = 3, TRPS = 6, TSELF = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sleep_req = 1'b0, wake_req = 1'b0, ref_gnt = 1'b0, bus_idle = 1'b0;
  logic ref_req, busy, ras_n, lcas_n, ucas_n;
  logic lp_req, lp_busy, lp_ras, lp_lcas, lp_ucas;
  int cyc = 0, nchk = 0, nfail = 0;
  bit finished = 1'b0;
  int seg_code[64], seg_len[64], nseg;
  int exp_code[64], exp_len[64], nexp;
  int split_bad;

  always #4 clk = ~clk;
  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  cbr_refresh_sched #(.LOW_POWER(0), .STD_IVAL(IVAL), .LP_IVAL(LPI), .PEND_W(PW), .ROWS(ROWS),
    .T_CSR(TCSR), .T_RAS(TRAS), .T_RP(TRP), .T_RPS(TRPS), .T_SELF(TSELF)) i_cbr_refresh_sched (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .wake_req(wake_req), .ref_gnt(ref_gnt),
    .bus_idle(bus_idle), .ref_req(ref_req), .busy(busy), .ras_n(ras_n), .lcas_n(lcas_n), .ucas_n(ucas_n));

  cbr_refresh_sched #(.LOW_POWER(1), .STD_IVAL(IVAL), .LP_IVAL(LPI), .PEND_W(PW), .ROWS(ROWS),
    .T_CSR(TCSR), .T_RAS(TRAS), .T_RP(TRP), .T_RPS(TRPS), .T_SELF(TSELF)) i_cbr_refresh_sched_lp (
    .clk(clk), .rst_n(rst_n), .sleep_req(1'b0), .wake_req(1'b0), .ref_gnt(1'b0),
    .bus_idle(1'b0), .ref_req(lp_req), .busy(lp_busy), .ras_n(lp_ras), .lcas_n(lp_lcas), .ucas_n(lp_ucas));

  task automatic chk(input string req, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_cyc(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic exp_add(input int code, input int len);
    exp_code[nexp] = code; exp_len[nexp] = len; nexp++;
  endtask

  task automatic exp_chain(input int k);
    exp_add(2, TCSR);
    for (int i = 0; i < k; i++) begin
      exp_add(0, TRAS);
      exp_add((i < k - 1) ? 2 : 3, TRP);
    end
  endtask

  task automatic run_session(input int wake_idx);
    int idx;
    int code;
    nseg = 0; idx = 0; split_bad = 0;
    while (!busy) @(negedge clk);
    while (busy) begin
      code = {30'd0, ras_n, lcas_n};
      if (ucas_n != lcas_n) split_bad++;
      if (nseg > 0 && seg_code[nseg-1] == code) seg_len[nseg-1]++;
      else if (nseg < 64) begin seg_code[nseg] = code; seg_len[nseg] = 1; nseg++; end
      wake_req = (idx == wake_idx);
      idx++;
      @(negedge clk);
    end
    wake_req = 1'b0;
  endtask

  task automatic compare_session(input string req);
    chk(req, "column strobes differ", split_bad, 0);
    chk(req, "segment count", nseg, nexp);
    for (int i = 0; i < nexp && i < nseg; i++) begin
      chk(req, $sformatf("segment %0d code", i), seg_code[i], exp_code[i]);
      chk(req, $sformatf("segment %0d length", i), seg_len[i], exp_len[i]);
    end
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk("R1", "ref_req in reset", int'(ref_req), 0);
    chk("R1", "busy in reset", int'(busy), 0);
    chk("R1", "strobes in reset", int'({ras_n, lcas_n, ucas_n}), 7);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "ref_req after reset", int'(ref_req), 0);
    chk("R12", "strobes idle", int'({ras_n, lcas_n, ucas_n}), 7);
  endtask

  task automatic t_interval;
    int first_main = -1, first_lp = -1;
    while (cyc < LPI) begin
      if (ref_req && first_main < 0) first_main = cyc;
      if (lp_req && first_lp < 0) first_lp = cyc;
      @(negedge clk);
    end
    if (lp_req && first_lp < 0) first_lp = cyc;
    chk("R2", "standard first request cycle", first_main, IVAL);
    chk("R2", "low-power first request cycle", first_lp, LPI);
  endtask

  task automatic t_withheld_then_burst;
    int bad_gnt = 0, bad_idle = 0;
    ref_gnt = 1'b0; bus_idle = 1'b1;
    while (cyc < 2 * IVAL + IVAL / 2) begin if (busy) bad_gnt++; @(negedge clk); end
    ref_gnt = 1'b1; bus_idle = 1'b0;
    while (cyc < 4 * IVAL) begin if (busy || !ras_n) bad_idle++; @(negedge clk); end
    chk("R3", "busy without grant", bad_gnt, 0);
    chk("R3", "busy while bus not idle", bad_idle, 0);
    bus_idle = 1'b1;
    @(negedge clk);
    chk("R3", "busy one cycle after grant", int'(busy), 1);
    chk("R3", "ref_req while busy", int'(ref_req), 0);
    nexp = 0; exp_chain(3);
    run_session(-1);
    compare_session("R7");
    chk("R6", "ref_req after paying off", int'(ref_req), 0);
    chk("R12", "strobes after release", int'({ras_n, lcas_n, ucas_n}), 7);
  endtask

  task automatic t_single;
    nexp = 0; exp_chain(1);
    run_session(-1);
    compare_session("R4");
  endtask

  task automatic t_sleep_early_wake;
    int rel;
    int first = -1;
    bus_idle = 1'b0;
    wait_cyc(7 * IVAL + 1);
    sleep_req = 1'b1; bus_idle = 1'b1;
    @(negedge clk);
    sleep_req = 1'b0;
    nexp = 0;
    exp_add(2, TCSR); exp_add(0, TSELF); exp_add(3, TRPS);
    exp_chain(ROWS);
    run_session(TCSR + 3);
    compare_session("R10");
    rel = cyc;
    while (cyc < rel + IVAL) begin
      if (ref_req && first < 0) first = cyc - rel;
      @(negedge clk);
    end
    if (ref_req && first < 0) first = cyc - rel;
    chk("R11", "first request after self-refresh", first, IVAL);
    nexp = 0; exp_chain(1);
    run_session(-1);
    compare_session("R5");
  endtask

  task automatic t_sleep_late_wake;
    int bad = 0;
    @(negedge clk);
    wake_req = 1'b1;
    @(negedge clk);
    wake_req = 1'b0;
    repeat (4) begin if (busy || ref_req) bad++; @(negedge clk); end
    chk("R9", "wake outside self-refresh", bad, 0);
    sleep_req = 1'b1;
    @(negedge clk);
    sleep_req = 1'b0;
    nexp = 0;
    exp_add(2, TCSR); exp_add(0, TSELF + 7); exp_add(3, TRPS);
    exp_chain(ROWS);
    run_session(TCSR + TSELF + 6);
    compare_session("R9");
    chk("R8", "hold length with late wake", seg_len[1], TSELF + 7);
  endtask

  initial begin
    #(8 * 20000);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_interval();
    t_withheld_then_burst();
    t_single();
    t_sleep_early_wake();
    t_sleep_late_wake();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule